// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block produces the operand of an instruction from a four-bit mode code, two register numbers, a two-bit scale code and a twelve-bit literal. It holds its own sixteen-entry, 32-bit register file and talks to a data memory through a read port with a one-cycle synchronous latency. Depending on the mode it returns a register value or the literal with no memory traffic. It can also form an address and read memory once, or read memory twice when the first read returns a pointer.

The surrounding pipeline pulses `start_i` while `busy_o` is low, with the fields valid in that cycle. It then waits for the one-cycle `done_o` pulse, which comes with the operand and the final memory address. The two auto modes step the base register by four bytes. The stepped value is already in the register file in the cycle `done_o` is high. Registers are loaded through a separate write port that takes effect only while the unit is idle.

Top module: `ea_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_rd_o` are low and every register file entry reads as zero.
- R2: Mode 0 (register) returns R[ri] with `addr_o` = 0 and no memory read. `done_o` rises on the first clock edge after the edge that accepts `start_i`.
- R3: Mode 1 (literal) returns the 12-bit literal sign-extended to 32 bits, with `addr_o` = 0, no memory read and the same timing as R2.
- R4: Mode 2 (absolute) reads the sign-extended literal as the address. Mode 3 (register indirect) reads address R[ri]. Each issues exactly one read, and `done_o` rises on the second edge after acceptance. The operand is the returned data and `addr_o` is the address read.
- R5: Mode 4 reads R[ri] + sext(literal) and mode 5 reads R[ri] + R[rj]. Both are single reads with R4 timing, and address arithmetic wraps modulo 2^32.
- R6: Mode 6 reads R[ri] + (R[rj] << s) + sext(literal). The scale code s is 0..3, giving factors 1, 2, 4 and 8. It is a single read with R4 timing.
- R7: Mode 7 (post-increment) and mode 8 (post-decrement) read address R[ri] as it was before the operation. They then write R[ri] + 4 or R[ri] - 4, modulo 2^32, into entry ri, and this value is visible by the cycle `done_o` is high. No other mode writes the register file.
- R8: Mode 9 (double indirect) reads R[ri] and then, on the next cycle, reads the returned word as an address. The operand is the second data word, `addr_o` is the second address, and `done_o` rises on the third edge after acceptance.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It does not change the result in progress and causes no extra `done_o`, and `done_o` is never high for two cycles in a row.
- R10: A write on the load port (`rf_we_i`, `rf_widx_i`, `rf_wdata_i`) updates the register file at the clock edge only while `busy_o` is low. While busy the write is dropped.
- R11: Mode codes 10 to 15 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request; accepted when `busy_o` is low |
| mode_i | input | 4 | Operand mode code |
| ri_i | input | 4 | Base register number |
| rj_i | input | 4 | Index register number |
| scale_i | input | 2 | Index scale code |
| imm_i | input | 12 | Literal / displacement |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| operand_o | output | 32 | Resulting operand |
| addr_o | output | 32 | Final memory address (0 for non-memory modes) |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_addr_o | output | 32 | Data memory read address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the strobe |
| rf_we_i | input | 1 | Register load write enable |
| rf_widx_i | input | 4 | Register load index |
| rf_wdata_i | input | 32 | Register load data |

## Verification
The bench builds the unit with its default parameters: sixteen 32-bit registers, a 12-bit literal, a 2-bit scale code and a step of four. The 12-bit literal lets a few directed cases reach the most negative displacement. At full 32-bit width, post-decrement of a zero register wraps to 0xFFFFFFFC, and the largest scale pushes a base-plus-scaled-index sum past 2^32. Random requests across all sixteen mode codes are mixed with stray start pulses and dropped register loads during busy cycles. The memory model returns address-derived data, so the double-indirect chain produces a new address each time.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_REG    = 4'd0,
    MD_IMM    = 4'd1,
    MD_ABS    = 4'd2,
    MD_RIND   = 4'd3,
    MD_BDISP  = 4'd4,
    MD_BIDX   = 4'd5,
    MD_SCALED = 4'd6,
    MD_AINC   = 4'd7,
    MD_ADEC   = 4'd8,
    MD_MIND   = 4'd9
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_RD1  = 2'd2,
    ST_RD2  = 2'd3
  } ea_state_e;

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] entry_q [NUM_REGS];
  logic [NUM_REGS-1:0] entry_we;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    assign entry_we[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (entry_we[g]) begin
        entry_q[g] <= wr_data;
      end
    end
  end

  assign rd_a_data = entry_q[rd_a_idx];
  assign rd_b_data = entry_q[rd_b_idx];

  AST_RF_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_we)); // R10

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 12,
  parameter int SCALE_W   = 2,
  parameter int AUTO_STEP = 4
) (
  input  logic [MODE_W-1:0]  mode,
  input  logic [DATA_W-1:0]  base,
  input  logic [DATA_W-1:0]  index,
  input  logic [SCALE_W-1:0] scale,
  input  logic [IMM_W-1:0]   imm,
  output logic [DATA_W-1:0]  ea,
  output logic               mem_op,
  output logic               indirect,
  output logic               wb_en,
  output logic [DATA_W-1:0]  wb_val,
  output logic [DATA_W-1:0]  direct_val
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(AUTO_STEP);

  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] idx_scaled;

  assign disp_ext   = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign idx_scaled = index << scale;

  always_comb begin
    ea         = '0;
    mem_op     = 1'b0;
    indirect   = 1'b0;
    wb_en      = 1'b0;
    wb_val     = base;
    direct_val = base;
    case (mode)
      MD_REG:    direct_val = base;
      MD_IMM:    direct_val = disp_ext;
      MD_ABS: begin
        mem_op = 1'b1;
        ea     = disp_ext;
      end
      MD_RIND: begin
        mem_op = 1'b1;
        ea     = base;
      end
      MD_BDISP: begin
        mem_op = 1'b1;
        ea     = base + disp_ext;
      end
      MD_BIDX: begin
        mem_op = 1'b1;
        ea     = base + index;
      end
      MD_SCALED: begin
        mem_op = 1'b1;
        ea     = base + idx_scaled + disp_ext;
      end
      MD_AINC: begin
        mem_op = 1'b1;
        ea     = base;
        wb_en  = 1'b1;
        wb_val = base + STEP;
      end
      MD_ADEC: begin
        mem_op = 1'b1;
        ea     = base;
        wb_en  = 1'b1;
        wb_val = base - STEP;
      end
      MD_MIND: begin
        mem_op   = 1'b1;
        indirect = 1'b1;
        ea       = base;
      end
      default:   direct_val = base;
    endcase
  end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mem_op_i,
  input  logic              indirect_i,
  input  logic              wb_req_i,
  input  logic [DATA_W-1:0] ea_i,
  input  logic [DATA_W-1:0] direct_val_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              latch_en_o,
  output logic              rf_wb_o,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              done_o,
  output logic [DATA_W-1:0] operand_o,
  output logic [DATA_W-1:0] addr_o
);

  ea_state_e         state_q, state_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] operand_q, operand_d;
  logic [DATA_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    operand_d  = operand_q;
    addr_d     = addr_q;
    addr_en    = 1'b0;
    latch_en_o = 1'b0;
    rf_wb_o    = 1'b0;
    mem_rd_o   = 1'b0;
    mem_addr_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          latch_en_o = 1'b1;
          state_d    = ST_EXEC;
        end
      end
      ST_EXEC: begin
        addr_en = 1'b1;
        if (mem_op_i) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = ea_i;
          addr_d     = ea_i;
          state_d    = ST_RD1;
        end else begin
          addr_d    = '0;
          done_d    = 1'b1;
          operand_d = direct_val_i;
          state_d   = ST_IDLE;
        end
      end
      ST_RD1: begin
        if (indirect_i) begin
          mem_rd_o   = 1'b1;
          mem_addr_o = mem_rdata_i;
          addr_en    = 1'b1;
          addr_d     = mem_rdata_i;
          state_d    = ST_RD2;
        end else begin
          done_d    = 1'b1;
          operand_d = mem_rdata_i;
          rf_wb_o   = wb_req_i;
          state_d   = ST_IDLE;
        end
      end
      ST_RD2: begin
        done_d    = 1'b1;
        operand_d = mem_rdata_i;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
    end else if (done_d) begin
      operand_q <= operand_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign operand_o = operand_q;
  assign addr_o    = addr_q;

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_BACK_TO_BACK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> indirect_i); // R8
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !mem_rd_o); // R2

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 16,
  parameter int IMM_W     = 12,
  parameter int SCALE_W   = 2,
  parameter int AUTO_STEP = 4,
  parameter int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [IDX_W-1:0]   ri_i,
  input  logic [IDX_W-1:0]   rj_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [IMM_W-1:0]   imm_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  operand_o,
  output logic [DATA_W-1:0]  addr_o,
  output logic               mem_rd_o,
  output logic [DATA_W-1:0]  mem_addr_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  input  logic               rf_we_i,
  input  logic [IDX_W-1:0]   rf_widx_i,
  input  logic [DATA_W-1:0]  rf_wdata_i
);

  logic [MODE_W-1:0]  mode_q;
  logic [IDX_W-1:0]   ri_q, rj_q;
  logic [SCALE_W-1:0] scale_q;
  logic [IMM_W-1:0]   imm_q;

  logic              latch_en;
  logic              rf_wb;
  logic [DATA_W-1:0] base_val, index_val;
  logic [DATA_W-1:0] ea, wb_val, direct_val;
  logic              mem_op, indirect, wb_req;
  logic              rf_wr_en;
  logic [IDX_W-1:0]  rf_wr_idx;
  logic [DATA_W-1:0] rf_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ri_q    <= '0;
      rj_q    <= '0;
      scale_q <= '0;
      imm_q   <= '0;
    end else if (latch_en) begin
      mode_q  <= mode_i;
      ri_q    <= ri_i;
      rj_q    <= rj_i;
      scale_q <= scale_i;
      imm_q   <= imm_i;
    end
  end

  always_comb begin
    rf_wr_en   = rf_wb || (rf_we_i && !busy_o);
    rf_wr_idx  = rf_wb ? ri_q : rf_widx_i;
    rf_wr_data = rf_wb ? wb_val : rf_wdata_i;
  end

  ea_regfile #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (ri_q),
    .rd_a_data (base_val),
    .rd_b_idx  (rj_q),
    .rd_b_data (index_val),
    .wr_en     (rf_wr_en),
    .wr_idx    (rf_wr_idx),
    .wr_data   (rf_wr_data)
  );

  ea_addr_calc #(
    .DATA_W    (DATA_W),
    .IMM_W     (IMM_W),
    .SCALE_W   (SCALE_W),
    .AUTO_STEP (AUTO_STEP)
  ) u_calc (
    .mode       (mode_q),
    .base       (base_val),
    .index      (index_val),
    .scale      (scale_q),
    .imm        (imm_q),
    .ea         (ea),
    .mem_op     (mem_op),
    .indirect   (indirect),
    .wb_en      (wb_req),
    .wb_val     (wb_val),
    .direct_val (direct_val)
  );

  ea_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_op_i     (mem_op),
    .indirect_i   (indirect),
    .wb_req_i     (wb_req),
    .ea_i         (ea),
    .direct_val_i (direct_val),
    .mem_rdata_i  (mem_rdata_i),
    .latch_en_o   (latch_en),
    .rf_wb_o      (rf_wb),
    .busy_o       (busy_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .done_o       (done_o),
    .operand_o    (operand_o),
    .addr_o       (addr_o)
  );

  AST_WB_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wb |-> (mode_q == MD_AINC || mode_q == MD_ADEC)); // R7
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wb |=> done_o); // R7
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o)); // R9
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> busy_o); // R2

endmodule

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [3:0]  ri, rj;
  logic [1:0]  scale;
  logic [11:0] imm;
  logic        busy, done, mem_rd;
  logic [31:0] operand, addr, mem_addr;
  logic [31:0] mem_rdata;
  logic        rf_we;
  logic [3:0]  rf_widx;
  logic [31:0] rf_wdata;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .ri_i(ri),
    .rj_i(rj), .scale_i(scale), .imm_i(imm), .busy_o(busy), .done_o(done),
    .operand_o(operand), .addr_o(addr), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .rf_we_i(rf_we),
    .rf_widx_i(rf_widx), .rf_wdata_i(rf_wdata)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[12:0], a[31:13]} ^ 32'hC3A5_5A3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= memf(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] md);
    case (md)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic wr_reg(input int idx, input logic [31:0] val);
    @(negedge clk);
    rf_we = 1'b1; rf_widx = 4'(idx); rf_wdata = val;
    @(negedge clk);
    rf_we = 1'b0;
    model[idx] = val;
  endtask

  task automatic run_op(input logic [3:0] md, input int a, input int b,
                        input int sc, input logic [11:0] lit, input bit poke);
    logic [31:0] sx, bv, iv, e_addr, e_op, e_next;
    int e_lat, e_rd, n, c0;
    string t;
    t  = tag_of(md);
    sx = {{20{lit[11]}}, lit};
    bv = model[a];
    iv = model[b];
    e_lat = 2; e_rd = 1; e_next = bv;
    case (md)
      4'd1: begin e_op = sx; e_addr = 0; e_lat = 1; e_rd = 0; end
      4'd2: e_addr = sx;
      4'd3: e_addr = bv;
      4'd4: e_addr = bv + sx;
      4'd5: e_addr = bv + iv;
      4'd6: e_addr = bv + (iv << sc) + sx;
      4'd7: begin e_addr = bv; e_next = bv + 32'd4; end
      4'd8: begin e_addr = bv; e_next = bv - 32'd4; end
      4'd9: begin e_addr = memf(bv); e_lat = 3; e_rd = 2; end
      default: begin e_op = bv; e_addr = 0; e_lat = 1; e_rd = 0; end
    endcase
    if (e_rd != 0) e_op = memf(e_addr);
    @(negedge clk);
    start = 1'b1; mode = md; ri = 4'(a); rj = 4'(b); scale = 2'(sc); imm = lit;
    c0 = rd_cnt;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9 stray request and R10 dropped load while busy
      start = 1'b1; mode = 4'd1; imm = 12'h5A5;
      rf_we = 1'b1; rf_widx = 4'd15; rf_wdata = 32'hDEAD_BEEF;
    end
    n = 0;
    while (n < 10) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0; rf_we = 1'b0;
      if (done) break;
    end
    chk(n == e_lat && done, t, "latency", 32'(n), 32'(e_lat));
    chk(operand == e_op, t, "operand", operand, e_op);
    chk(addr == e_addr, t, "address", addr, e_addr);
    chk(rd_cnt - c0 == e_rd, t, "reads", 32'(rd_cnt - c0), 32'(e_rd));
    model[a] = e_next;
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R9", "done pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240);
    rst_n = 1'b0; start = 1'b0; mode = 0; ri = 0; rj = 0; scale = 0; imm = 0;
    rf_we = 1'b0; rf_widx = 0; rf_wdata = 0;
    for (int k = 0; k < 16; k++) model[k] = 32'd0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1", "outputs in reset",
        {29'd0, busy, done, mem_rd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd, "R1", "outputs after reset",
        {29'd0, busy, done, mem_rd}, 32'd0);
    // R1: every register reads zero
    for (int k = 0; k < 16; k++) run_op(4'd0, k, 0, 0, 12'h0, 1'b0);

    for (int k = 0; k < 16; k++) wr_reg(k, 32'h1000_0000 + 32'(k) * 32'h0011_0040);
    // R10: load port value visible through register mode
    run_op(4'd0, 5, 0, 0, 12'h0, 1'b0);
    run_op(4'd1, 0, 0, 0, 12'h800, 1'b0);   // R3 most negative literal
    run_op(4'd1, 0, 0, 0, 12'h7FF, 1'b1);   // R3 largest positive literal
    run_op(4'd2, 0, 0, 0, 12'hFFC, 1'b0);   // R4 absolute, negative
    run_op(4'd3, 3, 0, 0, 12'h0, 1'b1);     // R4 register indirect
    run_op(4'd4, 2, 0, 0, 12'h800, 1'b0);   // R5 displacement -2048
    run_op(4'd5, 4, 9, 0, 12'h0, 1'b0);     // R5 base plus index
    wr_reg(6, 32'hF000_0000);
    wr_reg(7, 32'h3000_0001);
    for (int s = 0; s < 4; s++) run_op(4'd6, 6, 7, s, 12'h123, 1'b0); // R6 wrap
    wr_reg(8, 32'd0);
    run_op(4'd8, 8, 0, 0, 12'h0, 1'b1);     // R7 post-decrement wraps
    run_op(4'd0, 8, 0, 0, 12'h0, 1'b0);     // R7 base now 0xFFFFFFFC
    run_op(4'd7, 8, 0, 0, 12'h0, 1'b0);     // R7 post-increment back
    run_op(4'd0, 8, 0, 0, 12'h0, 1'b0);     // R7
    run_op(4'd9, 1, 0, 0, 12'h0, 1'b1);     // R8 double indirect
    run_op(4'd0, 15, 0, 0, 12'h0, 1'b0);    // R10 busy loads dropped
    run_op(4'd13, 11, 0, 0, 12'h0, 1'b0);   // R11 reserved code
    run_op(4'd15, 12, 0, 0, 12'h0, 1'b1);   // R11 reserved code

    for (int it = 0; it < 200; it++) begin
      if ((it % 25) == 0) wr_reg(int'($urandom_range(0, 14)), $urandom());
      run_op(4'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
             int'($urandom_range(0, 15)), int'($urandom_range(0, 3)),
             12'($urandom()), 1'($urandom()));
    end
    run_op(4'd0, 15, 0, 0, 12'h0, 1'b0);    // R10 after random pokes

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule